// File: doc/BRIEF.md
# SPI Flash Memory-Window Read Engine

This block lets a processor read a serial NOR flash as if it were memory. When the memory window is enabled, each word request on a simple valid/ready bus starts a complete SPI read transaction on the flash pins. The engine returns the 32-bit word once the last data bit has been captured and chip select has been released.

The transaction is built from a 32-bit format word. The format word sets four things. The first is an optional 8-bit command. The second is an address of zero to seven bytes, taken from the bus address. The third is a run of dummy cycles that carry a programmable pad byte. The fourth is four data bytes. The command, address and data phases each choose their own lane width: one, two or four data lines.

The SPI pins are shared with a software-driven transfer path. Software clears the window enable before it sends its own commands and sets it again when it is done. While the enable is clear and no engine transaction is in flight, the pins follow the software path.

Top module: `sflash_map_reader`

## Requirements
- R1: Out of reset, the window enable is set, `req_ready` is 1, `spi_cs_n` is 1 and `spi_sck` is 0. The format word is 0x0003_0007: command 0x03 enabled, 3 address bytes, no pad cycles, all phases single lane. A default read therefore takes 64 SCK cycles.
- R2: When format bit 0 is 1, the transaction begins with the 8-bit command code from format bits [23:16], sent MSB first. When bit 0 is 0 there is no command phase.
- R3: Format bits [3:1] give the address length N in bytes (0 to 7). The address phase sends the low N bytes of `req_addr`, MSB first. Bytes above bit 31 are sent as zero. When N is 0 there is no address phase.
- R4: Format bits [7:4] give P pad cycles. In these cycles the engine drives the pad byte from bits [31:24] MSB first, at the address lane width. Zeros follow once the byte is used up.
- R5: Lane codes sit in bits [9:8] for the command, [11:10] for the address and pad, and [13:12] for the data. The codes are: 0 single (out on dq0, in on dq1), 1 dual (dq[1:0], with dq1 more significant) and 2 quad (dq[3:0], with dq3 most significant). Code 3 behaves as single. In output phases `spi_dq_oe` is 0001, 0011 or 1111 to match the width. In the data phase it is 0000.
- R6: The data phase captures 32 bits. Each byte arrives MSB first. The first byte received is `rsp_data[7:0]` and the fourth is `rsp_data[31:24]`.
- R7: SPI mode 0 with SCK at half the clock rate: each SCK half lasts one clock, and SCK idles low. Outputs change while SCK is low and inputs are sampled at the end of the high half. `spi_cs_n` stays low without a break from the first beat to the end of the last data beat. The number of SCK cycles equals the sum of all phase beats.
- R8: A request is accepted when `req_valid` and `req_ready` are both 1. `req_ready` then stays 0 until the response. `rsp_valid` is a one-cycle pulse in the first cycle with `spi_cs_n` high after the transaction.
- R9: Format bits [15:14] are ignored. A format write changes only transactions accepted after it. A transaction in flight keeps the format it was accepted with.
- R10: Clearing the enable (`cfg_ctrl_we` with `cfg_ctrl_en`=0) drops `req_ready`, and no new transaction starts. A transaction in flight still completes. After that, all SPI outputs follow the `sw_*` inputs. Setting the enable again returns the pins to the idle engine, with `spi_cs_n` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_ctrl_we | input | 1 | Write strobe for the window enable |
| cfg_ctrl_en | input | 1 | New window enable value |
| cfg_fmt_we | input | 1 | Write strobe for the format word |
| cfg_fmt_wdata | input | 32 | New format word |
| req_valid | input | 1 | Read request valid |
| req_addr | input | ADDR_W | Read request address |
| req_ready | output | 1 | Engine can accept a request |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | 32 | Assembled read word |
| sw_cs_n | input | 1 | Software path chip select |
| sw_sck | input | 1 | Software path serial clock |
| sw_dq_o | input | 4 | Software path data out |
| sw_dq_oe | input | 4 | Software path output enables |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Flash serial clock |
| spi_dq_o | output | 4 | Flash data lines, driven values |
| spi_dq_oe | output | 4 | Flash data line output enables |
| spi_dq_i | input | 4 | Flash data lines, sampled values |

## Verification
A wrong beat count or phase order in this engine shows up as a wrong number of SCK rising edges inside one chip-select window. It also shifts the command, address or pad bit streams captured by the flash model, and that is visible when the same transaction ends. A wrong lane select or byte order is first seen at the `rsp_valid` pulse, as a wrong `rsp_data`. An ownership error in the pin switch is visible in the very cycle the software inputs are changed.

// File: rtl/sflash_rd_pkg.sv
package sflash_rd_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CMD,
        PH_ADDR,
        PH_PAD,
        PH_DATA,
        PH_DONE
    } phase_e;

    // Field positions match the format word layout.
    typedef struct packed {
        logic [7:0] pad_code;
        logic [7:0] cmd_code;
        logic [1:0] rsvd;
        logic [1:0] data_lanes;
        logic [1:0] addr_lanes;
        logic [1:0] cmd_lanes;
        logic [3:0] pad_cnt;
        logic [2:0] addr_bytes;
        logic       cmd_en;
    } fmt_t;

    localparam logic [31:0] FMT_RESET_WORD = 32'h0003_0007;

    // log2 of the number of lines per beat; code 3 falls back to single.
    function automatic logic [1:0] lane_shift(input logic [1:0] code);
        case (code)
            2'd1:    return 2'd1;
            2'd2:    return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/sflash_cfg.sv
module sflash_cfg
    import sflash_rd_pkg::*;
#(
    parameter logic [31:0] FMT_INIT = FMT_RESET_WORD,
    parameter bit          EN_INIT  = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctrl_we,
    input  logic        ctrl_en,
    input  logic        fmt_we,
    input  logic [31:0] fmt_wdata,
    output logic        flash_en,
    output fmt_t        fmt
);

    typedef struct packed {
        logic en;
        fmt_t fmt;
    } cfg_state_t;

    cfg_state_t s_d, s_q;
    logic       unused_rsvd_bits;

    assign unused_rsvd_bits = ^fmt_wdata[15:14];

    always_comb begin
        s_d = s_q;
        if (ctrl_we) begin
            s_d.en = ctrl_en;
        end
        if (fmt_we) begin
            s_d.fmt = fmt_t'({fmt_wdata[31:16], 2'b00, fmt_wdata[13:0]});
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.en  <= EN_INIT;
            s_q.fmt <= fmt_t'(FMT_INIT);
        end else begin
            s_q <= s_d;
        end
    end

    assign flash_en = s_q.en;
    assign fmt      = s_q.fmt;

endmodule

// File: rtl/sflash_seq.sv
module sflash_seq
    import sflash_rd_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    input  fmt_t              fmt_i,
    input  logic [3:0]        dq_i,
    output logic              busy,
    output logic              cs_n,
    output logic              sck,
    output logic [3:0]        dq_o,
    output logic [3:0]        dq_oe,
    output logic              rsp_valid,
    output logic [31:0]       rsp_data
);

    localparam int SH_W   = 64;
    localparam int BEAT_W = 6;
    localparam int WORD_W = 32;

    typedef struct packed {
        phase_e              phase;
        logic                half;
        logic [BEAT_W-1:0]   beats;
        logic [SH_W-1:0]     sh;
        logic [SH_W-1:0]     addr_al;
        logic [WORD_W-1:0]   rx;
        fmt_t                fmt;
    } seq_t;

    seq_t s_d, s_q;

    // Phase that follows p, skipping phases the format leaves empty.
    function automatic phase_e follow(input phase_e p, input fmt_t f);
        if (p == PH_IDLE && f.cmd_en)                               return PH_CMD;
        if ((p == PH_IDLE || p == PH_CMD) && f.addr_bytes != 3'd0)  return PH_ADDR;
        if ((p == PH_IDLE || p == PH_CMD || p == PH_ADDR) && f.pad_cnt != 4'd0)
                                                                    return PH_PAD;
        if (p != PH_DATA)                                           return PH_DATA;
        return PH_DONE;
    endfunction

    function automatic logic [1:0] phase_lanes(input phase_e p, input fmt_t f);
        case (p)
            PH_CMD:         return f.cmd_lanes;
            PH_ADDR, PH_PAD: return f.addr_lanes;
            PH_DATA:        return f.data_lanes;
            default:        return 2'd0;
        endcase
    endfunction

    function automatic logic [BEAT_W-1:0] phase_beats(input phase_e p, input fmt_t f);
        case (p)
            PH_CMD:  return BEAT_W'(8) >> lane_shift(f.cmd_lanes);
            PH_ADDR: return {f.addr_bytes, 3'b000} >> lane_shift(f.addr_lanes);
            PH_PAD:  return BEAT_W'(f.pad_cnt);
            PH_DATA: return BEAT_W'(WORD_W) >> lane_shift(f.data_lanes);
            default: return '0;
        endcase
    endfunction

    function automatic logic [SH_W-1:0] phase_load(input phase_e p, input fmt_t f,
                                                   input logic [SH_W-1:0] al);
        case (p)
            PH_CMD:  return {f.cmd_code, {(SH_W-8){1'b0}}};
            PH_ADDR: return al;
            PH_PAD:  return {f.pad_code, {(SH_W-8){1'b0}}};
            default: return '0;
        endcase
    endfunction

    always_comb begin
        logic [SH_W-1:0] addr_w;
        logic [6:0]      amt;
        logic [SH_W-1:0] al_new;
        logic [1:0]      w;
        phase_e          first;
        phase_e          nxt;

        s_d    = s_q;
        addr_w = SH_W'(addr);
        amt    = 7'd64 - {1'b0, fmt_i.addr_bytes, 3'b000};
        al_new = addr_w << amt;
        w      = lane_shift(phase_lanes(s_q.phase, s_q.fmt));
        first  = follow(PH_IDLE, fmt_i);
        nxt    = follow(s_q.phase, s_q.fmt);

        case (s_q.phase)
            PH_IDLE: begin
                if (start) begin
                    s_d.fmt     = fmt_i;
                    s_d.addr_al = al_new;
                    s_d.rx      = '0;
                    s_d.half    = 1'b0;
                    s_d.phase   = first;
                    s_d.beats   = phase_beats(first, fmt_i);
                    s_d.sh      = phase_load(first, fmt_i, al_new);
                end
            end
            PH_DONE: begin
                s_d.phase = PH_IDLE;
            end
            default: begin
                if (!s_q.half) begin
                    s_d.half = 1'b1;
                end else begin
                    s_d.half = 1'b0;
                    case (w)
                        2'd1:    s_d.sh = s_q.sh << 2;
                        2'd2:    s_d.sh = s_q.sh << 4;
                        default: s_d.sh = s_q.sh << 1;
                    endcase
                    if (s_q.phase == PH_DATA) begin
                        case (w)
                            2'd1:    s_d.rx = {s_q.rx[WORD_W-3:0], dq_i[1:0]};
                            2'd2:    s_d.rx = {s_q.rx[WORD_W-5:0], dq_i};
                            default: s_d.rx = {s_q.rx[WORD_W-2:0], dq_i[1]};
                        endcase
                    end
                    if (s_q.beats == BEAT_W'(1)) begin
                        s_d.phase = nxt;
                        s_d.beats = phase_beats(nxt, s_q.fmt);
                        s_d.sh    = phase_load(nxt, s_q.fmt, s_q.addr_al);
                    end else begin
                        s_d.beats = s_q.beats - BEAT_W'(1);
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_IDLE, half: 1'b0, beats: '0, sh: '0,
                     addr_al: '0, rx: '0, fmt: fmt_t'(FMT_RESET_WORD)};
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        logic [1:0] lw;
        lw    = lane_shift(phase_lanes(s_q.phase, s_q.fmt));
        dq_o  = 4'b0000;
        dq_oe = 4'b0000;
        if (s_q.phase == PH_CMD || s_q.phase == PH_ADDR || s_q.phase == PH_PAD) begin
            case (lw)
                2'd1: begin
                    dq_o  = {2'b00, s_q.sh[SH_W-1 -: 2]};
                    dq_oe = 4'b0011;
                end
                2'd2: begin
                    dq_o  = s_q.sh[SH_W-1 -: 4];
                    dq_oe = 4'b1111;
                end
                default: begin
                    dq_o  = {3'b000, s_q.sh[SH_W-1]};
                    dq_oe = 4'b0001;
                end
            endcase
        end
    end

    assign busy      = (s_q.phase != PH_IDLE);
    assign cs_n      = (s_q.phase == PH_IDLE) || (s_q.phase == PH_DONE);
    assign sck       = s_q.half;
    assign rsp_valid = (s_q.phase == PH_DONE);
    assign rsp_data  = {s_q.rx[7:0], s_q.rx[15:8], s_q.rx[23:16], s_q.rx[31:24]};

endmodule

// File: rtl/sflash_pinmux.sv
module sflash_pinmux (
    input  logic       eng_own,
    input  logic       eng_cs_n,
    input  logic       eng_sck,
    input  logic [3:0] eng_dq_o,
    input  logic [3:0] eng_dq_oe,
    input  logic       sw_cs_n,
    input  logic       sw_sck,
    input  logic [3:0] sw_dq_o,
    input  logic [3:0] sw_dq_oe,
    output logic       pin_cs_n,
    output logic       pin_sck,
    output logic [3:0] pin_dq_o,
    output logic [3:0] pin_dq_oe
);

    always_comb begin
        if (eng_own) begin
            pin_cs_n  = eng_cs_n;
            pin_sck   = eng_sck;
            pin_dq_o  = eng_dq_o;
            pin_dq_oe = eng_dq_oe;
        end else begin
            pin_cs_n  = sw_cs_n;
            pin_sck   = sw_sck;
            pin_dq_o  = sw_dq_o;
            pin_dq_oe = sw_dq_oe;
        end
    end

endmodule

// File: rtl/sflash_map_reader.sv
module sflash_map_reader
    import sflash_rd_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_ctrl_we,
    input  logic              cfg_ctrl_en,
    input  logic              cfg_fmt_we,
    input  logic [31:0]       cfg_fmt_wdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [31:0]       rsp_data,
    input  logic              sw_cs_n,
    input  logic              sw_sck,
    input  logic [3:0]        sw_dq_o,
    input  logic [3:0]        sw_dq_oe,
    output logic              spi_cs_n,
    output logic              spi_sck,
    output logic [3:0]        spi_dq_o,
    output logic [3:0]        spi_dq_oe,
    input  logic [3:0]        spi_dq_i
);

    logic       flash_en;
    fmt_t       fmt;
    logic       seq_busy;
    logic       eng_own;
    logic       eng_cs_n;
    logic       eng_sck;
    logic [3:0] eng_dq_o;
    logic [3:0] eng_dq_oe;
    logic       start;

    sflash_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_we   (cfg_ctrl_we),
        .ctrl_en   (cfg_ctrl_en),
        .fmt_we    (cfg_fmt_we),
        .fmt_wdata (cfg_fmt_wdata),
        .flash_en  (flash_en),
        .fmt       (fmt)
    );

    assign req_ready = flash_en && !seq_busy;
    assign start     = req_valid && req_ready;
    assign eng_own   = flash_en || seq_busy;

    sflash_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .addr      (req_addr),
        .fmt_i     (fmt),
        .dq_i      (spi_dq_i),
        .busy      (seq_busy),
        .cs_n      (eng_cs_n),
        .sck       (eng_sck),
        .dq_o      (eng_dq_o),
        .dq_oe     (eng_dq_oe),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    sflash_pinmux u_mux (
        .eng_own   (eng_own),
        .eng_cs_n  (eng_cs_n),
        .eng_sck   (eng_sck),
        .eng_dq_o  (eng_dq_o),
        .eng_dq_oe (eng_dq_oe),
        .sw_cs_n   (sw_cs_n),
        .sw_sck    (sw_sck),
        .sw_dq_o   (sw_dq_o),
        .sw_dq_oe  (sw_dq_oe),
        .pin_cs_n  (spi_cs_n),
        .pin_sck   (spi_sck),
        .pin_dq_o  (spi_dq_o),
        .pin_dq_oe (spi_dq_oe)
    );

endmodule

// File: rtl/sflash_map_reader_chk.sv
module sflash_map_reader_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       flash_en,
    input logic       seq_busy,
    input logic       eng_own,
    input logic       req_valid,
    input logic       req_ready,
    input logic       rsp_valid,
    input logic       spi_cs_n,
    input logic       spi_sck,
    input logic [3:0] spi_dq_oe
);

    assert_rsp_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_accept_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready && !spi_cs_n));

    assert_rsp_after_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (spi_cs_n && !req_ready));

    assert_cs_unbroken_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_busy && !spi_cs_n) |=> (!spi_cs_n || rsp_valid));

    assert_sck_half_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_busy && !spi_cs_n && spi_sck) |=> !spi_sck);

    assert_sck_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_own && spi_cs_n) |-> !spi_sck);

    assert_oe_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
        eng_own |-> (spi_dq_oe == 4'b0000 || spi_dq_oe == 4'b0001 ||
                     spi_dq_oe == 4'b0011 || spi_dq_oe == 4'b1111));

    assert_no_start_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!flash_en && !seq_busy) |=> !seq_busy);

endmodule

bind sflash_map_reader sflash_map_reader_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flash_en  (flash_en),
    .seq_busy  (seq_busy),
    .eng_own   (eng_own),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .spi_cs_n  (spi_cs_n),
    .spi_sck   (spi_sck),
    .spi_dq_oe (spi_dq_oe)
);

// File: tb/sflash_map_reader_test.sv
module sflash_map_reader_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_ctrl_we = 1'b0, cfg_ctrl_en = 1'b0, cfg_fmt_we = 1'b0;
    logic [31:0] cfg_fmt_wdata = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_ready, rsp_valid;
    logic [31:0] rsp_data;
    logic        sw_cs_n = 1'b1, sw_sck = 1'b0;
    logic [3:0]  sw_dq_o = '0, sw_dq_oe = '0;
    logic        spi_cs_n, spi_sck;
    logic [3:0]  spi_dq_o, spi_dq_oe;
    logic [3:0]  spi_dq_i = '0;

    sflash_map_reader uut (.*);

    always #4 clk = ~clk;

    typedef struct {
        logic [31:0] addr;
        logic [31:0] fmt;
    } item_t;

    item_t       exp_q[$];
    int          vecs = 0, errs = 0;
    logic [31:0] cur_fmt = 32'h0003_0007;
    int          last_k = 0;
    bit          finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        vecs++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int wof(input logic [1:0] c);
        return (c == 2'd1) ? 2 : (c == 2'd2) ? 4 : 1;
    endfunction

    function automatic logic [31:0] dev_word(input logic [31:0] a);
        logic [7:0] b[4];
        for (int i = 0; i < 4; i++) b[i] = a[7:0] ^ (8'h3C + 8'h29 * 8'(i)) ^ a[15:8];
        return {b[3], b[2], b[1], b[0]};
    endfunction

    function automatic int n_cmd(input logic [31:0] f);
        return f[0] ? 8 / wof(f[9:8]) : 0;
    endfunction
    function automatic int n_addr(input logic [31:0] f);
        return int'(f[3:1]) * 8 / wof(f[11:10]);
    endfunction
    function automatic int n_data(input logic [31:0] f);
        return 32 / wof(f[13:12]);
    endfunction

    // ---------------- flash device model ----------------
    bit          active = 1'b0;
    int          k = 0, oe_bad = 0;
    logic [63:0] cap_cmd, cap_addr, cap_pad;
    logic [31:0] mfmt, maddr;

    task automatic drive_beat();
        int          ds, j, w;
        logic [31:0] wd, st;
        logic [3:0]  b;
        ds = n_cmd(mfmt) + n_addr(mfmt) + int'(mfmt[7:4]);
        w  = wof(mfmt[13:12]);
        j  = k - ds;
        if (j >= 0 && j < n_data(mfmt)) begin
            wd = dev_word(maddr);
            st = {wd[7:0], wd[15:8], wd[23:16], wd[31:24]};
            b  = 4'((st >> (32 - (j + 1) * w)) & ((32'd1 << w) - 1));
            if (w == 1)      spi_dq_i = b[0] ? 4'b0010 : 4'b1101;
            else if (w == 2) spi_dq_i = {2'b10, b[1:0]};
            else             spi_dq_i = b;
        end
    endtask

    always @(negedge spi_cs_n) begin
        if (exp_q.size() > 0) begin
            active = 1'b1; k = 0; oe_bad = 0;
            cap_cmd = '0; cap_addr = '0; cap_pad = '0;
            mfmt = exp_q[0].fmt; maddr = exp_q[0].addr;
            drive_beat();
        end
    end

    always @(negedge spi_sck) if (active && !spi_cs_n) drive_beat();

    always @(posedge spi_sck) begin
        if (active && !spi_cs_n) begin
            int cb, ab, pb, w;
            logic [3:0] m;
            cb = n_cmd(mfmt); ab = n_addr(mfmt); pb = int'(mfmt[7:4]);
            if (k < cb)                w = wof(mfmt[9:8]);
            else if (k < cb + ab + pb) w = wof(mfmt[11:10]);
            else                       w = 0;
            m = (w == 4) ? 4'hF : (w == 2) ? 4'h3 : (w == 1) ? 4'h1 : 4'h0;
            if (spi_dq_oe != m) oe_bad++;
            if (k < cb)                cap_cmd  = (cap_cmd  << w) | 64'(spi_dq_o & m);
            else if (k < cb + ab)      cap_addr = (cap_addr << w) | 64'(spi_dq_o & m);
            else if (k < cb + ab + pb) cap_pad  = (cap_pad  << w) | 64'(spi_dq_o & m);
            k++;
        end
    end

    always @(posedge spi_cs_n) begin
        if (active) begin
            int          tot, nb;
            logic [63:0] e_addr, e_pad;
            active = 1'b0;
            last_k = k;
            tot = n_cmd(mfmt) + n_addr(mfmt) + int'(mfmt[7:4]) + n_data(mfmt);
            chk(k == tot, "R7", "SCK cycles in CS window", 64'(k), 64'(tot));
            chk(cap_cmd == (mfmt[0] ? 64'(mfmt[23:16]) : 64'd0), "R2", "command bits",
                cap_cmd, mfmt[0] ? 64'(mfmt[23:16]) : 64'd0);
            e_addr = 64'(maddr) & ((64'd1 << (8 * int'(mfmt[3:1]))) - 64'd1);
            chk(cap_addr == e_addr, "R3", "address bits", cap_addr, e_addr);
            nb = int'(mfmt[7:4]) * wof(mfmt[11:10]);
            e_pad = '0;
            for (int i = 0; i < nb; i++) e_pad = (e_pad << 1) | 64'((i < 8) ? mfmt[31 - i] : 1'b0);
            chk(cap_pad == e_pad, "R4", "pad bits", cap_pad, e_pad);
            chk(oe_bad == 0, "R5", "output-enable mismatches", 64'(oe_bad), 64'd0);
        end
    end

    // ---------------- response monitor ----------------
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            chk(spi_cs_n == 1'b1, "R8", "cs_n at response", 64'(spi_cs_n), 64'd1);
            if (exp_q.size() > 0) begin
                item_t it;
                it = exp_q.pop_front();
                chk(rsp_data == dev_word(it.addr), "R6", "read word",
                    64'(rsp_data), 64'(dev_word(it.addr)));
            end else begin
                chk(1'b0, "R8", "unexpected response", 64'(rsp_data), 64'd0);
            end
        end
    end

    // ---------------- driver ----------------
    task automatic start_read(input logic [31:0] a);
        item_t it;
        it.addr = a; it.fmt = cur_fmt;
        exp_q.push_back(it);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready && !spi_cs_n, "R8", "ready low and cs low after accept",
            64'({req_ready, spi_cs_n}), 64'd0);
    endtask

    task automatic wait_done();
        while (exp_q.size() > 0) @(negedge clk);
    endtask

    task automatic do_read(input logic [31:0] a);
        start_read(a);
        wait_done();
    endtask

    task automatic write_fmt(input logic [31:0] w);
        @(negedge clk);
        cfg_fmt_we = 1'b1; cfg_fmt_wdata = w;
        @(negedge clk);
        cfg_fmt_we = 1'b0;
        cur_fmt = w & ~32'h0000_C000;
    endtask

    task automatic set_en(input logic b);
        @(negedge clk);
        cfg_ctrl_we = 1'b1; cfg_ctrl_en = b;
        @(negedge clk);
        cfg_ctrl_we = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        vecs++; errs++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1", "req_ready after reset", 64'(req_ready), 64'd1);
        chk(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R1", "idle pins after reset",
            64'({spi_cs_n, spi_sck}), 64'h2);
        chk(rsp_valid == 1'b0, "R1", "no response after reset", 64'(rsp_valid), 64'd0);

        // R1 default format: cmd 0x03, 3 address bytes, single lanes
        do_read(32'h00A1_B2C3);
        chk(last_k == 64, "R1", "default SCK count", 64'(last_k), 64'd64);

        // Quad address and data, pad 6 cycles with 0xF0
        write_fmt(32'hF0EB_2867);
        do_read(32'h0012_3456);
        do_read(32'h00FE_DCBA);

        // Dual on every phase, 4-byte address, pad 2, reserved bits set (R9)
        write_fmt(32'h5ABB_D529);
        do_read(32'hDEAD_BEEF);

        // No command, no address, no pad, dual data: data phase only
        write_fmt(32'h0000_1000);
        do_read(32'h0000_0011);
        chk(last_k == 16, "R5", "dual data-only SCK count", 64'(last_k), 64'd16);

        // 5-byte address (zero upper byte), 15 pad cycles, lane code 3 = single
        write_fmt(32'hC30B_30FB);
        do_read(32'h8765_4321);

        // Back-to-back quad reads
        write_fmt(32'h99EB_2A09);
        do_read(32'h0000_1000);
        do_read(32'h0000_1004);

        // R9: format write during a transaction only affects the next one
        write_fmt(32'h0003_0007);
        start_read(32'h0040_0080);
        repeat (20) @(negedge clk);
        write_fmt(32'h0000_2000);
        wait_done();
        chk(last_k == 64, "R9", "in-flight kept old format", 64'(last_k), 64'd64);
        do_read(32'h0000_00F0);
        chk(last_k == 8, "R9", "next read uses new format", 64'(last_k), 64'd8);

        // R10: disable during a transaction
        write_fmt(32'h0003_0007);
        sw_dq_oe = 4'h6; sw_dq_o = 4'h9;
        start_read(32'h0033_4455);
        repeat (10) @(negedge clk);
        set_en(1'b0);
        @(negedge clk);
        chk(spi_cs_n == 1'b0, "R10", "in-flight keeps pins", 64'(spi_cs_n), 64'd0);
        wait_done();
        @(negedge clk);
        chk(req_ready == 1'b0, "R10", "ready low when disabled", 64'(req_ready), 64'd0);
        chk(spi_dq_oe == 4'h6 && spi_dq_o == 4'h9, "R10", "pins follow software",
            64'({spi_dq_oe, spi_dq_o}), 64'h69);
        sw_sck = 1'b1; sw_cs_n = 1'b0;
        @(negedge clk);
        chk(spi_sck == 1'b1 && spi_cs_n == 1'b0, "R10", "software sck/cs",
            64'({spi_sck, spi_cs_n}), 64'h2);
        sw_sck = 1'b0; sw_cs_n = 1'b1;
        req_valid = 1'b1; req_addr = 32'h1;
        begin
            int seen = 0;
            repeat (6) begin
                @(negedge clk);
                if (rsp_valid || spi_cs_n != sw_cs_n) seen++;
            end
            chk(seen == 0, "R10", "request ignored while disabled", 64'(seen), 64'd0);
        end
        req_valid = 1'b0;
        sw_cs_n = 1'b0;
        set_en(1'b1);
        @(negedge clk);
        chk(req_ready == 1'b1 && spi_cs_n == 1'b1, "R10", "engine owns pins again",
            64'({req_ready, spi_cs_n}), 64'h3);
        sw_cs_n = 1'b1;
        do_read(32'h0000_7777);

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule